// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block sits between two 8-bit bidirectional buses, called A and B, and moves data between them in either direction. Each direction owns a capture register with its own clock. The A-side register samples the A bus and the B-side register samples the B bus. For each direction a source select decides what reaches the far bus: either the live value from the near bus, which is a combinational pass-through, or the contents of that direction's register.

A single active-low enable and a direction input decide which bus, if any, the block drives. The three-state pins are modelled as a split input, output and output-enable per bus. A pad wrapper higher up would join them. Capture never depends on the enable, direction or select controls. The registers therefore keep sampling even while both buses are isolated. A subsequent switch into stored mode then presents the value that was captured.

Top module: `regbus_xcvr`

## Requirements
- R1: On a rising edge of `cap_ab_clk`, the A-side register loads `a_in`. On a rising edge of `cap_ba_clk`, the B-side register loads `b_in`.
- R2: Capture happens on every such edge, whatever the values of `en_n`, `dir` and the two selects. This includes edges that occur while both buses are isolated.
- R3: While `en_n` is 1, both `a_oe` and `b_oe` are 0.
- R4: While `en_n` is 0, `dir` = 1 gives `b_oe` = 1 and `a_oe` = 0, and `dir` = 0 gives `a_oe` = 1 and `b_oe` = 0.
- R5: With `src_ab` = 0, `b_out` equals the present `a_in` combinationally, with no clock needed.
- R6: With `src_ab` = 1, `b_out` equals the A-side register and ignores changes on `a_in` between clock edges.
- R7: With `src_ba` = 0, `a_out` equals the present `b_in`. With `src_ba` = 1, `a_out` equals the B-side register.
- R8: In stored mode, the value captured at a clock edge appears on the opposite bus output right after that same edge. No further edge is needed.
- R9: `rst` = 1 clears both registers to 0 asynchronously.
- R10: A register keeps its value across edges of the other direction's clock. It also keeps its value across any change of the select, enable or direction inputs.
- R11: A bus output whose output-enable is 0 reads all zeros.
- R12: `a_oe` and `b_oe` are never 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst | input | 1 | Asynchronous clear of both registers, active high |
| cap_ab_clk | input | 1 | Capture clock of the A-side register |
| cap_ba_clk | input | 1 | Capture clock of the B-side register |
| en_n | input | 1 | Output enable for both buses, active low |
| dir | input | 1 | 1 drives bus B, 0 drives bus A |
| src_ab | input | 1 | Source for bus B: 0 live A, 1 A-side register |
| src_ba | input | 1 | Source for bus A: 0 live B, 1 B-side register |
| a_in | input | 8 | Value sensed on bus A |
| a_out | output | 8 | Value driven onto bus A |
| a_oe | output | 1 | Drive enable for bus A |
| b_in | input | 8 | Value sensed on bus B |
| b_out | output | 8 | Value driven onto bus B |
| b_oe | output | 1 | Drive enable for bus B |

## Verification
In stored mode, a register capture and the output it feeds change at the same clock edge. The bench sets a fresh value on the near bus and raises that direction's clock. It then samples the far output one nanosecond later, while the clock is still high, and expects the new value there and not the old one. A second overlap is covered by raising both capture clocks in the same instant. Each register is then read back through stored mode, and each must hold its own bus value with no crosstalk between the two.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

   // Which bus the block currently drives
   typedef enum logic [1:0] {
      DRV_NONE = 2'd0,
      DRV_BUSA = 2'd1,
      DRV_BUSB = 2'd2
   } drive_e;

   function automatic drive_e decode_drive(input logic en_n, input logic dir);
      if (en_n)     return DRV_NONE;
      else if (dir) return DRV_BUSB;
      else          return DRV_BUSA;
   endfunction

endpackage

// File: rtl/xcvr_drive_ctrl.sv
module xcvr_drive_ctrl
   import xcvr_pkg::*;
(
   input  logic en_n,
   input  logic dir,
   output logic drv_a,
   output logic drv_b
);

   drive_e state;

   always_comb begin
      state = decode_drive(en_n, dir);
      drv_a = 1'b0;
      drv_b = 1'b0;
      case (state)
         DRV_BUSA: drv_a = 1'b1;
         DRV_BUSB: drv_b = 1'b1;
         default: begin
            drv_a = 1'b0;
            drv_b = 1'b0;
         end
      endcase
   end

endmodule

// File: rtl/xcvr_capture_reg.sv
module xcvr_capture_reg #(
   parameter int              WIDTH   = 8,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   if (WIDTH < 1) begin : g_bad_width
      $error("xcvr_capture_reg: WIDTH must be at least 1");
   end

   always_ff @(posedge clk or posedge rst) begin
      if (rst) q <= RST_VAL;
      else     q <= d;
   end

endmodule

// File: rtl/xcvr_path_sel.sv
module xcvr_path_sel #(
   parameter int WIDTH     = 8,
   parameter bit GATE_IDLE = 1'b1
) (
   input  logic [WIDTH-1:0] live,
   input  logic [WIDTH-1:0] stored,
   input  logic             use_stored,
   input  logic             drive,
   output logic [WIDTH-1:0] y
);

   if (WIDTH < 1) begin : g_bad_width
      $error("xcvr_path_sel: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] pick;
   assign pick = use_stored ? stored : live;

   if (GATE_IDLE) begin : g_gated
      assign y = drive ? pick : '0;
   end else begin : g_raw
      // drive is only meaningful to the pad wrapper in this variant
      logic unused_drive;
      assign unused_drive = drive;
      assign y = pick;
   end

endmodule

// File: rtl/regbus_xcvr.sv
module regbus_xcvr #(
   parameter int               WIDTH     = 8,
   parameter logic [WIDTH-1:0] RST_VAL   = '0,
   parameter bit               GATE_IDLE = 1'b1
) (
   input  logic             rst,
   input  logic             cap_ab_clk,
   input  logic             cap_ba_clk,
   input  logic             en_n,
   input  logic             dir,
   input  logic             src_ab,
   input  logic             src_ba,
   input  logic [WIDTH-1:0] a_in,
   output logic [WIDTH-1:0] a_out,
   output logic             a_oe,
   input  logic [WIDTH-1:0] b_in,
   output logic [WIDTH-1:0] b_out,
   output logic             b_oe
);

   if (WIDTH < 1) begin : g_bad_width
      $error("regbus_xcvr: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] q_a;
   logic [WIDTH-1:0] q_b;

   xcvr_drive_ctrl u_drive (
      .en_n  (en_n),
      .dir   (dir),
      .drv_a (a_oe),
      .drv_b (b_oe)
   );

   xcvr_capture_reg #(.WIDTH(WIDTH), .RST_VAL(RST_VAL)) u_reg_a (
      .clk (cap_ab_clk),
      .rst (rst),
      .d   (a_in),
      .q   (q_a)
   );

   xcvr_capture_reg #(.WIDTH(WIDTH), .RST_VAL(RST_VAL)) u_reg_b (
      .clk (cap_ba_clk),
      .rst (rst),
      .d   (b_in),
      .q   (q_b)
   );

   xcvr_path_sel #(.WIDTH(WIDTH), .GATE_IDLE(GATE_IDLE)) u_sel_to_b (
      .live       (a_in),
      .stored     (q_a),
      .use_stored (src_ab),
      .drive      (b_oe),
      .y          (b_out)
   );

   xcvr_path_sel #(.WIDTH(WIDTH), .GATE_IDLE(GATE_IDLE)) u_sel_to_a (
      .live       (b_in),
      .stored     (q_b),
      .use_stored (src_ba),
      .drive      (a_oe),
      .y          (a_out)
   );

   // R1
   cap_a_chk: assert property (@(posedge cap_ab_clk) disable iff (rst)
      $past(!rst) |-> (q_a == $past(a_in)));

   // R1
   cap_b_chk: assert property (@(posedge cap_ba_clk) disable iff (rst)
      $past(!rst) |-> (q_b == $past(b_in)));

   // R12
   oe_mutex_chk: assert property (@(posedge cap_ab_clk) disable iff (rst)
      !(a_oe && b_oe));

   // R3
   isolate_chk: assert property (@(posedge cap_ba_clk) disable iff (rst)
      en_n |-> (!a_oe && !b_oe));

   // R5
   live_ab_chk: assert property (@(posedge cap_ab_clk) disable iff (rst)
      (b_oe && !src_ab) |-> (b_out == a_in));

   // R7
   stored_ba_chk: assert property (@(posedge cap_ba_clk) disable iff (rst)
      (a_oe && src_ba) |-> (a_out == q_b));

endmodule

// File: tb/regbus_xcvr_tb.sv
module regbus_xcvr_tb;

   localparam int W = 8;

   logic         tb_clk = 1'b0;
   logic         rst = 1'b1;
   logic         cap_ab_clk = 1'b0;
   logic         cap_ba_clk = 1'b0;
   logic         en_n = 1'b1;
   logic         dir = 1'b0;
   logic         src_ab = 1'b0;
   logic         src_ba = 1'b0;
   logic [W-1:0] a_in = '0;
   logic [W-1:0] b_in = '0;
   logic [W-1:0] a_out;
   logic [W-1:0] b_out;
   logic         a_oe;
   logic         b_oe;

   int checks = 0;
   int errors = 0;
   int ticks = 0;
   logic [W-1:0] ma = '0;
   logic [W-1:0] mb = '0;

   regbus_xcvr #(.WIDTH(W)) u_dut (
      .rst(rst), .cap_ab_clk(cap_ab_clk), .cap_ba_clk(cap_ba_clk),
      .en_n(en_n), .dir(dir), .src_ab(src_ab), .src_ba(src_ba),
      .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
      .b_in(b_in), .b_out(b_out), .b_oe(b_oe)
   );

   always #4 tb_clk = ~tb_clk;

   always @(posedge tb_clk) begin
      ticks <= ticks + 1;
      if (ticks > 100000) begin
         errors = errors + 1;
         $display("FAIL watchdog expired got %0d exp <100000", ticks);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic chk(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
      checks = checks + 1;
      if (got !== exp) begin
         errors = errors + 1;
         $display("FAIL %s got %h exp %h", req, got, exp);
      end
   endtask

   task automatic pulse_ab();
      cap_ab_clk = 1'b1; ma = a_in; #4;
      cap_ab_clk = 1'b0; #4;
   endtask

   task automatic pulse_ba();
      cap_ba_clk = 1'b1; mb = b_in; #4;
      cap_ba_clk = 1'b0; #4;
   endtask

   // read A-side register through stored mode on bus B
   task automatic peek_a(input string req, input logic [W-1:0] exp);
      en_n = 1'b0; dir = 1'b1; src_ab = 1'b1; #1;
      chk(req, b_out, exp);
   endtask

   task automatic peek_b(input string req, input logic [W-1:0] exp);
      en_n = 1'b0; dir = 1'b0; src_ba = 1'b1; #1;
      chk(req, a_out, exp);
   endtask

   task automatic t_reset();
      a_in = 8'hFF; b_in = 8'hEE; #2;
      chk("R3 a_oe in reset", {7'b0, a_oe}, 8'h00);
      chk("R3 b_oe in reset", {7'b0, b_oe}, 8'h00);
      chk("R11 a_out idle", a_out, 8'h00);
      rst = 1'b0; #2;
      peek_a("R9 A reg cleared", 8'h00);
      peek_b("R9 B reg cleared", 8'h00);
   endtask

   task automatic t_isolated_capture();
      en_n = 1'b1; src_ab = 1'b1; src_ba = 1'b1;
      a_in = 8'h3C; #1; pulse_ab();
      b_in = 8'hA5; #1; pulse_ba();
      chk("R3 a_oe isolated", {7'b0, a_oe}, 8'h00);
      chk("R11 a_out isolated", a_out, 8'h00);
      chk("R11 b_out isolated", b_out, 8'h00);
      peek_a("R2 A captured while isolated", 8'h3C);
      peek_b("R2 B captured while isolated", 8'hA5);
   endtask

   task automatic t_live();
      en_n = 1'b0; dir = 1'b1; src_ab = 1'b0;
      for (int i = 0; i < 4; i++) begin
         a_in = 8'h11 << i ^ 8'h81; #1;
         chk("R5 live A to B", b_out, a_in);
      end
      chk("R4 b_oe with dir=1", {7'b0, b_oe}, 8'h01);
      chk("R11 a_out undriven", a_out, 8'h00);
      dir = 1'b0; src_ba = 1'b0;
      for (int i = 0; i < 4; i++) begin
         b_in = 8'hC3 ^ (8'h05 << i); #1;
         chk("R7 live B to A", a_out, b_in);
      end
      chk("R4 a_oe with dir=0", {7'b0, a_oe}, 8'h01);
   endtask

   task automatic t_stored_same_edge();
      en_n = 1'b0; dir = 1'b1; src_ab = 1'b1;
      a_in = 8'h5A; #1;
      cap_ab_clk = 1'b1; ma = a_in; #1;
      chk("R8 new A value at same edge", b_out, 8'h5A);
      #3; cap_ab_clk = 1'b0; #4;
      a_in = 8'h11; #1;
      chk("R6 stored ignores a_in", b_out, 8'h5A);
      dir = 1'b0; src_ba = 1'b1;
      b_in = 8'h96; #1;
      cap_ba_clk = 1'b1; mb = b_in; #1;
      chk("R8 new B value at same edge", a_out, 8'h96);
      #3; cap_ba_clk = 1'b0; #4;
      b_in = 8'h00; #1;
      chk("R7 stored ignores b_in", a_out, 8'h96);
   endtask

   task automatic t_cross_clock();
      logic [W-1:0] old_a;
      old_a = ma;
      a_in = 8'h77; b_in = 8'h99; #1;
      pulse_ba(); pulse_ba();
      peek_a("R10 A held across B clocks", old_a);
      peek_b("R1 B captured", 8'h99);
      b_in = 8'h12; a_in = 8'h34; #1;
      pulse_ab();
      peek_b("R10 B held across A clock", 8'h99);
      peek_a("R1 A captured", 8'h34);
   endtask

   task automatic t_select_switch();
      en_n = 1'b0; dir = 1'b1; a_in = 8'hF0; src_ab = 1'b0; #1;
      chk("R5 live after switch", b_out, 8'hF0);
      src_ab = 1'b1; #1;
      chk("R6 stored after switch", b_out, ma);
      src_ab = 1'b0; #1; src_ab = 1'b1; en_n = 1'b1; dir = 1'b0; #1;
      peek_a("R10 A kept across select change", ma);
      peek_b("R10 B kept across select change", mb);
   endtask

   task automatic t_both_clocks();
      a_in = 8'h6E; b_in = 8'hD1; #1;
      cap_ab_clk = 1'b1; cap_ba_clk = 1'b1; ma = a_in; mb = b_in; #4;
      cap_ab_clk = 1'b0; cap_ba_clk = 1'b0; #4;
      a_in = 8'h00; b_in = 8'h00;
      peek_a("R1 A on joint edge", 8'h6E);
      peek_b("R1 B on joint edge", 8'hD1);
   endtask

   // every combination of enable, direction and the two selects
   task automatic t_matrix();
      a_in = 8'h2B; b_in = 8'hB4;
      for (int k = 0; k < 16; k++) begin
         logic e_a;
         logic e_b;
         logic [W-1:0] x_a;
         logic [W-1:0] x_b;
         {en_n, dir, src_ab, src_ba} = 4'(k); #1;
         e_a = !en_n && !dir;
         e_b = !en_n && dir;
         x_b = e_b ? (src_ab ? ma : a_in) : '0;
         x_a = e_a ? (src_ba ? mb : b_in) : '0;
         chk("R12 oe pair", {6'b0, a_oe, b_oe}, {6'b0, e_a, e_b});
         chk("R4 b_out matrix", b_out, x_b);
         chk("R7 a_out matrix", a_out, x_a);
      end
   endtask

   initial begin
      #3;
      t_reset();
      t_isolated_capture();
      t_live();
      t_stored_same_edge();
      t_cross_clock();
      t_select_switch();
      t_both_clocks();
      t_matrix();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule